// File: doc/BRIEF.md
# LED Chain PWM Frame Streamer

This block drives the single data line of a chain of serially addressed RGB LEDs. A free-running period counter produces one LED bit time per period. Its compare register is reloaded at every period boundary from a frame buffer, so each period becomes a high pulse of one of two widths. A short pulse encodes a zero bit and a long pulse encodes a one bit.

The buffer has one duty entry per colour bit, followed by a run of zero-duty gap slots that form the latch gap. Playback is circular: the line repeats the frame for as long as the block is out of reset. A host updates one LED per cycle through a write port that carries the LED index and its red, green and blue bytes. The block expands those bytes into duty codes in place. A frame already playing can show a partly updated chain, because no tearing protection exists.

Top module: `led_pwm_streamer`

## Requirements
- R1: Every period lasts PERIOD_TICKS clock cycles (default 125, 1.25 µs at 100 MHz). During a period `led_dout` is high from the first cycle for exactly the loaded compare value in cycles, then low for the rest of the period.
- R2: A zero bit plays as a high time of ZERO_HIGH cycles (default 35, 350 ns). A one bit plays as ONE_HIGH cycles (default 80, 800 ns). No other nonzero high time occurs.
- R3: LED n owns buffer slots 24·n to 24·n+23. Within them green comes first, then red, then blue, and each byte goes most significant bit first. Slot 24·n + 8·k + (7−b) carries bit b of byte k, where k = 0 is green, 1 is red and 2 is blue.
- R4: After the NUM_LEDS·24 data slots come GAP_SLOTS slots (default 50) that always play with zero duty, so the line is low for the whole period.
- R5: After reset every data slot holds the zero-bit code. The compare register starts at 0, so the first period after reset is entirely low. Slot 0 plays in the second period.
- R6: The compare value is preloaded. It changes only at a period boundary, so a buffer write never alters the period already running. The written slots take effect when playback next reaches them.
- R7: After the last gap slot, playback wraps to slot 0 without a pause and repeats the frame indefinitely.
- R8: A write with `wr_en` high updates all 24 slots of LED `wr_led` in one cycle while playback continues. Slots of other LEDs are unchanged.
- R9: Asserting `rst_n` low at any time returns the buffer, the counter and the output to the state of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one LED colour |
| wr_led | input | LED_W | Index of the LED to update |
| wr_red | input | 8 | Red byte |
| wr_green | input | 8 | Green byte |
| wr_blue | input | 8 | Blue byte |
| led_dout | output | 1 | Serial LED data line |

## Verification
A wrong compare value shows up within the same period as a pulse of the wrong width. A slot pointer off by one shifts every later bit, so the error appears in the first period after the slip. A wrong wrap or a wrong gap length makes the first data bit of the next frame appear a whole number of periods early or late. Every period after reset is checked for pulse width and shape against a model of the buffer, across more than one frame, so these faults show up within one frame time.

// File: rtl/led_pwm_streamer.sv
module led_pwm_streamer #(
  parameter int NUM_LEDS     = 4,
  parameter int PERIOD_TICKS = 125,
  parameter int ZERO_HIGH    = 35,
  parameter int ONE_HIGH     = 80,
  parameter int GAP_SLOTS    = 50,
  parameter int LED_W        = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LED_W-1:0] wr_led,
  input  logic [7:0]       wr_red,
  input  logic [7:0]       wr_green,
  input  logic [7:0]       wr_blue,
  output logic             led_dout
);
  localparam int DATA_SLOTS = NUM_LEDS * 24;
  localparam int SLOTS      = DATA_SLOTS + GAP_SLOTS;
  localparam int CW         = $clog2(PERIOD_TICKS);
  localparam int IW         = $clog2(SLOTS);
  localparam logic [CW-1:0] CODE0 = CW'(ZERO_HIGH);
  localparam logic [CW-1:0] CODE1 = CW'(ONE_HIGH);
  localparam logic [CW-1:0] LAST_TICK = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] tick, cmp_q, next_duty;
  logic [IW-1:0] slot;
  logic [CW-1:0] duty_mem [DATA_SLOTS];
  logic [23:0]   colour;

  assign colour    = {wr_green, wr_red, wr_blue};
  assign next_duty = (slot < IW'(DATA_SLOTS)) ? duty_mem[slot] : '0;
  assign led_dout  = tick < cmp_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < NUM_LEDS; l++) begin
      for (int e = 0; e < 24; e++) begin
        if (!rst_n)
          duty_mem[l*24+e] <= CODE0;
        else if (wr_en && wr_led == LED_W'(l))
          duty_mem[l*24+e] <= colour[23-e] ? CODE1 : CODE0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick  <= '0;
      cmp_q <= '0;
      slot  <= '0;
    end else if (tick == LAST_TICK) begin
      tick  <= '0;
      cmp_q <= next_duty;
      slot  <= (slot == IW'(SLOTS - 1)) ? '0 : slot + 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end
endmodule

// File: rtl/led_pwm_streamer_chk.sv
module led_pwm_streamer_chk #(
  parameter int PERIOD_TICKS = 125,
  parameter int ZERO_HIGH    = 35,
  parameter int ONE_HIGH     = 80,
  parameter int DATA_SLOTS   = 96,
  parameter int SLOTS        = 146,
  parameter int CW           = 7,
  parameter int IW           = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tick,
  input logic [CW-1:0] cmp_q,
  input logic [IW-1:0] slot,
  input logic          led_dout
);
  localparam logic [CW-1:0] LAST_TICK = CW'(PERIOD_TICKS - 1);

  a_r1_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= LAST_TICK);
  a_r1_low_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tick == LAST_TICK |-> !led_dout);
  a_r1_high_head: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == '0 && cmp_q != '0) |-> led_dout);
  a_r2_codes: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q == '0 || cmp_q == CW'(ZERO_HIGH) || cmp_q == CW'(ONE_HIGH));
  a_r6_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tick != LAST_TICK |=> $stable(cmp_q));
  a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == LAST_TICK && slot >= IW'(DATA_SLOTS)) |=> cmp_q == '0);
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == LAST_TICK && slot == IW'(SLOTS - 1)) |=> slot == '0);
endmodule

bind led_pwm_streamer led_pwm_streamer_chk #(
  .PERIOD_TICKS(PERIOD_TICKS), .ZERO_HIGH(ZERO_HIGH), .ONE_HIGH(ONE_HIGH),
  .DATA_SLOTS(DATA_SLOTS), .SLOTS(SLOTS), .CW(CW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_q(cmp_q), .slot(slot), .led_dout(led_dout)
);

// File: tb/led_pwm_streamer_bench.sv
module led_pwm_streamer_bench;
  localparam int NUM_LEDS = 4;
  localparam int PER      = 125;
  localparam int Z        = 35;
  localparam int O        = 80;
  localparam int GAP      = 50;
  localparam int DATA     = NUM_LEDS * 24;
  localparam int SLOTS    = DATA + GAP;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_led = 0;
  logic [7:0] wr_red = 0, wr_green = 0, wr_blue = 0;
  logic led_dout;

  int checks = 0, errors = 0, pidx = 0;
  int exp_buf [SLOTS];
  bit pend = 0;
  int p_led; logic [7:0] p_r, p_g, p_b;

  always #5 clk = ~clk;

  led_pwm_streamer u_led_pwm_streamer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_led(wr_led),
    .wr_red(wr_red), .wr_green(wr_green), .wr_blue(wr_blue), .led_dout(led_dout)
  );

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) exp_buf[i] = (i < DATA) ? Z : 0;
    pidx = 0;
  endtask

  task automatic model_write(int led, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    logic [23:0] c;
    c = {g, r, b};
    for (int e = 0; e < 24; e++) exp_buf[24*led+e] = c[23-e] ? O : Z;
  endtask

  // called at a negedge where the period counter reads 0
  task automatic run_periods(int n, string tag);
    for (int k = 0; k < n; k++) begin
      int exp_h, hi, slot_no;
      bit shape_ok;
      slot_no = (pidx == 0) ? -1 : (pidx - 1) % SLOTS;
      exp_h = (pidx == 0) ? 0 : exp_buf[slot_no];
      hi = 0; shape_ok = 1;
      for (int s = 0; s < PER; s++) begin
        if (led_dout) hi++;
        if (led_dout !== (s < exp_h)) shape_ok = 0;
        if (s == 0 && pend) begin
          wr_en = 1; wr_led = p_led[1:0]; wr_red = p_r; wr_green = p_g; wr_blue = p_b;
        end
        if (s == 1 && pend) begin
          wr_en = 0; pend = 0;
          model_write(p_led, p_r, p_g, p_b);
        end
        @(negedge clk);
      end
      checks++;
      if (!shape_ok || hi != exp_h) begin
        errors++;
        $display("FAIL %s period %0d slot %0d: high %0d expected %0d (shape_ok=%0d)",
                 tag, pidx, slot_no, hi, exp_h, shape_ok);
      end
      pidx++;
    end
  endtask

  task automatic post_write(int led, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    pend = 1; p_led = led; p_r = r; p_g = g; p_b = b;
  endtask

  task automatic run_to_slot(int target, string tag);
    while (pidx == 0 || (pidx - 1) % SLOTS != target) run_periods(1, tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (led_dout !== 1'b0) begin
      errors++;
      $display("FAIL R9 output during reset: %b expected 0", led_dout);
    end
    rst_n = 1;
    model_reset();
  endtask

  task automatic test_reset_state();
    do_reset();
    run_periods(1, "R5 first period low");
    run_periods(SLOTS, "R5/R2/R4 default frame");
  endtask

  task automatic test_bit_order();
    post_write(0, 8'h3C, 8'hA5, 8'h0F);
    run_periods(1, "R8 write");
    post_write(NUM_LEDS - 1, 8'h81, 8'h01, 8'h80);
    run_periods(1, "R8 write");
    run_to_slot(0, "R3");
    run_periods(SLOTS, "R3/R2/R4 written frame");
  endtask

  task automatic test_preload();
    run_to_slot(24, "R6 align");
    post_write(1, 8'hFF, 8'hFF, 8'hFF);
    run_periods(30, "R6 write mid-period");
    run_to_slot(23, "R6 next frame");
    run_periods(26, "R6/R8 new value played");
  endtask

  task automatic test_wrap();
    run_to_slot(SLOTS - 2, "R7 align");
    run_periods(4, "R7 wrap to slot 0");
  endtask

  task automatic test_mid_reset();
    run_periods(7, "R9 pre");
    do_reset();
    run_periods(1 + SLOTS, "R9 state restored");
  endtask

  initial begin
    fork
      begin
        test_reset_state();
        test_bit_order();
        test_preload();
        test_wrap();
        test_mid_reset();
      end
      begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual hung, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule